// File: doc/BRIEF.md
# Three-Pin Bidirectional Port with External-Bus Takeover

This block is a small general-purpose I/O port of three pins. Software reaches it through two registers on an internal register bus: an output latch and a direction register. The direction register decides, pin by pin, whether that pin drives its latch bit or floats as an input. Reading the port register returns the pin levels as seen from outside, after they pass through a synchronizer. It does not return the latch.

A two-bit operating-mode input can hand the pins to an external memory bus. In that case the pins stop acting as I/O and always drive the three control strobes of a multiplexed address/data bus. Those strobes are an address latch enable (active high), a read/output enable (active low) and a write strobe (active low). They are generated by a separate bus-cycle controller and only routed here.

Register writes are still accepted while the pins are taken over. They take effect on the pins once the mode returns to general I/O. The register bus has no back-pressure: a write completes at the next clock edge, and read data is valid in the same cycle that the bank and address are presented.

Top module: `gpio3_busmux`

## Requirements
- R1: While and after reset, the output latch holds 000 and the direction register holds 111. With the mode in general I/O, no pin is driven (`pad_oe` = 000) and `pad_out` = 000.
- R2: In general I/O modes (`op_mode[1]` = 0), a direction bit of 1 makes its pin an input (`pad_oe` bit = 0) and a 0 makes it an output (`pad_oe` bit = 1). `pad_out` always carries the latch bits.
- R3: A read at register address 0 returns in bits 2:0 the pin levels sampled through two flops. A change on `pad_in` shows up in `reg_rdata` after the second rising edge, not after the first.
- R4: Address 0 writes `reg_wdata[2:0]` into the output latch only, whatever the direction bits are. Address 1 writes the direction register and reads it back. Bits 7:3 of either register always read 0.
- R5: Both registers react only when `reg_bank` equals 1. With any other bank value, writes are ignored and `reg_rdata` reads 0.
- R6: When `op_mode[1]` = 1 (modes 2'b10 extended microcontroller and 2'b11 microprocessor), all three pins are driven (`pad_oe` = 111). Pin 0 carries `xb_latch_en`, pin 1 carries `xb_rd_n` and pin 2 carries `xb_wr_n`, whatever the latch and direction hold. Modes 2'b00 and 2'b01 are general I/O.
- R7: Writes made while the pins carry bus strobes are stored. They appear on the pins as soon as the mode returns to general I/O.
- R8: A read in the same cycle as a write to the same register returns the value from before that clock edge. The new value is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 2 | Operating mode; bit 1 set hands pins to the external bus |
| reg_bank | input | 4 | Bank select value of the register bus |
| reg_addr | input | 1 | Register select: 0 output latch / pin levels, 1 direction |
| reg_wr | input | 1 | Write strobe, takes effect at the next rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from bank and address |
| xb_latch_en | input | 1 | Address latch enable from the bus-cycle controller (idle low) |
| xb_rd_n | input | 1 | Active-low output enable from the bus-cycle controller (idle high) |
| xb_wr_n | input | 1 | Active-low write strobe from the bus-cycle controller (idle high) |
| pad_in | input | 3 | Levels seen at the pins |
| pad_out | output | 3 | Value each pin drives when enabled |
| pad_oe | output | 3 | Driver enable per pin, 1 = driving |

## Verification
The hardest situation to reach is a register write that lands while the pins belong to the external bus. From the pins alone it is invisible, so the stimulus writes a fresh latch and direction pattern in bus mode. It then checks that the strobes stay on the pins, and then drops the mode back to I/O to see the stored pattern appear. The two-flop input latency is probed by sampling the read data after one edge and again after two. The pre-edge read is caught by sampling `reg_rdata` while the write strobe is still asserted.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;
  typedef enum logic [1:0] {
    MODE_MCU      = 2'b00,
    MODE_MCU_PROT = 2'b01,
    MODE_EXT_MCU  = 2'b10,
    MODE_UPROC    = 2'b11
  } op_mode_e;

  localparam logic REG_SEL_DATA = 1'b0;
  localparam logic REG_SEL_DIR  = 1'b1;

  localparam int STROBE_COUNT = 3;

  function automatic logic mode_is_bus(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/g3_sync.sv
module g3_sync #(
  parameter int PINS   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] d_in,
  output logic [PINS-1:0] q_out
);
  logic [PINS-1:0] st [STAGES];
  logic            armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) st[0] <= '0;
          else        st[0] <= d_in;
        end
        // R3
        first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
          armed |-> st[0] == $past(d_in));
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) st[k] <= '0;
          else        st[k] <= st[k-1];
        end
        // R3
        chain_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
          armed |-> st[k] == $past(st[k-1]));
      end
    end
  endgenerate

  assign q_out = st[STAGES-1];
endmodule

// File: rtl/g3_regfile.sv
module g3_regfile
  import gpio3_pkg::*;
#(
  parameter int PINS     = 3,
  parameter int DW       = 8,
  parameter int BANK_W   = 4,
  parameter int OWN_BANK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic [PINS-1:0]   pin_sync,
  output logic [DW-1:0]     rdata,
  output logic [PINS-1:0]   latch_q,
  output logic [PINS-1:0]   dir_q
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(OWN_BANK);

  logic hit;
  assign hit = (bank == MY_BANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else if (hit && wr) begin
      if (addr == REG_SEL_DATA) latch_q <= wdata[PINS-1:0];
      else                      dir_q   <= wdata[PINS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      if (addr == REG_SEL_DATA) rdata[PINS-1:0] = pin_sync;
      else                      rdata[PINS-1:0] = dir_q;
    end
  end

  // R5
  bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(latch_q) && $stable(dir_q));

  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr && addr == REG_SEL_DATA) |=> latch_q == $past(wdata[PINS-1:0]));

  // R4
  dir_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr && addr == REG_SEL_DATA) |=> $stable(dir_q));

  // R4
  latch_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr && addr == REG_SEL_DIR) |=> $stable(latch_q));
endmodule

// File: rtl/g3_pinmux.sv
module g3_pinmux
  import gpio3_pkg::*;
#(
  parameter int PINS = 3
) (
  input  logic                    bus_sel,
  input  logic [PINS-1:0]         latch_q,
  input  logic [PINS-1:0]         dir_q,
  input  logic [STROBE_COUNT-1:0] strobes,
  output logic [PINS-1:0]         pin_out,
  output logic [PINS-1:0]         pin_oe
);
  genvar i;
  generate
    for (i = 0; i < PINS; i++) begin : g_pin
      if (i < STROBE_COUNT) begin : g_shared
        assign pin_out[i] = bus_sel ? strobes[i] : latch_q[i];
        assign pin_oe[i]  = bus_sel | ~dir_q[i];
      end else begin : g_plain
        assign pin_out[i] = latch_q[i];
        assign pin_oe[i]  = ~dir_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio3_busmux.sv
module gpio3_busmux
  import gpio3_pkg::*;
#(
  parameter int PINS        = 3,
  parameter int DW          = 8,
  parameter int BANK_W      = 4,
  parameter int OWN_BANK    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic [BANK_W-1:0] reg_bank,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              xb_latch_en,
  input  logic              xb_rd_n,
  input  logic              xb_wr_n,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic [PINS-1:0]         pin_sync;
  logic [PINS-1:0]         latch_q;
  logic [PINS-1:0]         dir_q;
  logic [STROBE_COUNT-1:0] strobes;
  logic                    bus_sel;

  assign bus_sel = mode_is_bus(op_mode);
  assign strobes = {xb_wr_n, xb_rd_n, xb_latch_en};

  g3_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_in),
    .q_out (pin_sync)
  );

  g3_regfile #(.PINS(PINS), .DW(DW), .BANK_W(BANK_W), .OWN_BANK(OWN_BANK)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank     (reg_bank),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .pin_sync (pin_sync),
    .rdata    (reg_rdata),
    .latch_q  (latch_q),
    .dir_q    (dir_q)
  );

  g3_pinmux #(.PINS(PINS)) u_mux (
    .bus_sel (bus_sel),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .strobes (strobes),
    .pin_out (pad_out),
    .pin_oe  (pad_oe)
  );

  // R4
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:PINS] == '0);

  // R7
  bus_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !reg_wr) |=> (!bus_sel) |-> pad_out == $past(latch_q));
endmodule

// File: tb/gpio3_busmux_tb.sv
module gpio3_busmux_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic [3:0] reg_bank = 4'd0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       xb_latch_en = 1'b0;
  logic       xb_rd_n = 1'b1;
  logic       xb_wr_n = 1'b1;
  logic [2:0] pad_in = 3'b000;
  logic [2:0] pad_out;
  logic [2:0] pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio3_busmux u_dut (
    .clk (clk), .rst_n (rst_n), .op_mode (op_mode),
    .reg_bank (reg_bank), .reg_addr (reg_addr), .reg_wr (reg_wr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .xb_latch_en (xb_latch_en), .xb_rd_n (xb_rd_n), .xb_wr_n (xb_wr_n),
    .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe)
  );

  // vector: mode[16:15] dir[14:12] lat[11:9] strobes{wr_n,rd_n,le}[8:6] exp_oe[5:3] exp_out[2:0]
  localparam int NVEC = 7;
  localparam logic [16:0] VEC [NVEC] = '{
    {2'b00, 3'b111, 3'b101, 3'b110, 3'b000, 3'b101},
    {2'b01, 3'b000, 3'b011, 3'b110, 3'b111, 3'b011},
    {2'b00, 3'b011, 3'b100, 3'b110, 3'b100, 3'b100},
    {2'b10, 3'b111, 3'b000, 3'b110, 3'b111, 3'b110},
    {2'b11, 3'b010, 3'b111, 3'b001, 3'b111, 3'b001},
    {2'b11, 3'b000, 3'b000, 3'b101, 3'b111, 3'b101},
    {2'b01, 3'b101, 3'b010, 3'b110, 3'b010, 3'b010}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] b, input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_bank = b; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] b, input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_bank = b; reg_addr = a; reg_wr = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    // R1: state during reset
    #1 chk("R1 oe in reset", {5'd0, pad_oe}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 oe after reset", {5'd0, pad_oe}, 8'h00);
    chk("R1 out after reset", {5'd0, pad_out}, 8'h00);
    rd_reg(4'd1, 1'b1, rv);
    chk("R1 dir reset value", rv, 8'h07);

    // R2 / R6: table walk
    for (int v = 0; v < NVEC; v++) begin
      wr_reg(4'd1, 1'b1, {5'd0, VEC[v][14:12]});
      wr_reg(4'd1, 1'b0, {5'd0, VEC[v][11:9]});
      @(negedge clk);
      op_mode = VEC[v][16:15];
      {xb_wr_n, xb_rd_n, xb_latch_en} = VEC[v][8:6];
      #1;
      chk(VEC[v][16] ? "R6 oe vec" : "R2 oe vec", {5'd0, pad_oe}, {5'd0, VEC[v][5:3]});
      chk(VEC[v][16] ? "R6 out vec" : "R2 out vec", {5'd0, pad_out}, {5'd0, VEC[v][2:0]});
    end
    op_mode = 2'b00;
    {xb_wr_n, xb_rd_n, xb_latch_en} = 3'b110;

    // R3: two-flop latency on pin reads
    @(negedge clk);
    pad_in = 3'b101; reg_bank = 4'd1; reg_addr = 1'b0;
    @(negedge clk);
    #1 chk("R3 one edge still old", reg_rdata, 8'h00);
    @(negedge clk);
    #1 chk("R3 two edges new", reg_rdata, 8'h05);

    // R4: latch write with all inputs, upper bits, read shows pins not latch
    wr_reg(4'd1, 1'b1, 8'hFF);
    rd_reg(4'd1, 1'b1, rv);
    chk("R4 dir upper bits zero", rv, 8'h07);
    wr_reg(4'd1, 1'b0, 8'hFA);
    rd_reg(4'd1, 1'b0, rv);
    chk("R4 data read is pins", rv, 8'h05);
    chk("R4 oe still off", {5'd0, pad_oe}, 8'h00);
    wr_reg(4'd1, 1'b1, 8'h00);
    #1 chk("R4 latch took write", {5'd0, pad_out}, 8'h02);
    chk("R2 all outputs", {5'd0, pad_oe}, 8'h07);

    // R5: other banks ignored
    wr_reg(4'd0, 1'b1, 8'h07);
    wr_reg(4'd2, 1'b0, 8'h05);
    #1 chk("R5 dir kept", {5'd0, pad_oe}, 8'h07);
    chk("R5 latch kept", {5'd0, pad_out}, 8'h02);
    rd_reg(4'd2, 1'b1, rv);
    chk("R5 foreign read zero", rv, 8'h00);

    // R7: writes during bus mode stored
    @(negedge clk);
    op_mode = 2'b11;
    {xb_wr_n, xb_rd_n, xb_latch_en} = 3'b011;
    wr_reg(4'd1, 1'b0, 8'h04);
    wr_reg(4'd1, 1'b1, 8'h01);
    #1 chk("R7 strobes held", {5'd0, pad_out}, 8'h03);
    chk("R7 all driven", {5'd0, pad_oe}, 8'h07);
    @(negedge clk);
    op_mode = 2'b01;
    #1 chk("R7 latch shows", {5'd0, pad_out}, 8'h04);
    chk("R7 dir shows", {5'd0, pad_oe}, 8'h06);

    // R8: read during write sees old value
    @(negedge clk);
    reg_bank = 4'd1; reg_addr = 1'b1; reg_wdata = 8'h05; reg_wr = 1'b1;
    #1 chk("R8 pre-edge dir", reg_rdata, 8'h01);
    @(negedge clk);
    reg_wr = 1'b0;
    #1 chk("R8 post-edge dir", reg_rdata, 8'h05);

    // R1: reset again restores defaults
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 re-reset oe", {5'd0, pad_oe}, 8'h00);
    chk("R1 re-reset latch", {5'd0, pad_out}, 8'h00);

    summary();
  end
endmodule